// File: doc/BRIEF.md
# I2C Transmit Byte Stage with Clock Stretching

This block is the transmit data path of an I2C controller. Software places the next byte into a one-byte holding register. At the end of the acknowledge clock of the byte on the wire, the block hands that byte to a shift register and presents it on SDA, most significant bit first. A separate bit-level SCL/SDA engine produces the clock strobes and reports which clock of the byte is ending. The engine itself is not part of this block.

When the acknowledge clock ends and no byte is waiting, the block does not underrun. It asks the engine to hold SCL low until software writes a byte. That byte then goes straight into the shift register, and the stretch request drops on the next cycle. A frame-start strobe from the engine counts as a byte boundary, so the first byte of a transfer is handed over in the same way. A write made while the holding register is still occupied is discarded, and a sticky overrun flag records it.

Top module: `i2c_tx_stage`

## Requirements
- R1: After reset, `tx_empty` is 1, `scl_hold` is 0, `sda_out` is 1 (released) and `overrun` is 0.
- R2: A write (`wr_en` high for one cycle) while `tx_empty` is 1, outside a stretch and outside a boundary cycle, stores `wr_data`, and `tx_empty` reads 0 from the next cycle.
- R3: A byte boundary is a cycle with `scl_fall` high and `bit_idx` equal to 8, the acknowledge clock. At a boundary with a byte waiting, that byte enters the shift register. In the following cycle `tx_empty` is 1, `scl_hold` is 0 and `sda_out` shows bit 7 of the byte.
- R4: Bits go out MSB first. After a `scl_fall` with `bit_idx` equal to k (k from 0 to 6), `sda_out` shows bit 6-k of the current byte.
- R5: After a `scl_fall` with `bit_idx` equal to 7, `sda_out` is 1 for the acknowledge clock.
- R6: At a boundary with no byte waiting and no write in that cycle, `scl_hold` rises in the next cycle and stays high until a write arrives. A stretch never begins on any other cycle.
- R7: A write during a stretch loads the shift register directly. In the next cycle `scl_hold` is 0, `sda_out` shows bit 7 of the new byte, and `tx_empty` stays 1.
- R8: A write while `tx_empty` is 0 leaves the held byte unchanged, sets `overrun`, and `overrun` stays 1 until reset.
- R9: `sda_out` changes only in the cycle after a `scl_fall`, a `frame_start` or a `wr_en`, that is, only while SCL is low.
- R10: A `frame_start` pulse acts as a byte boundary: the waiting byte is loaded (R3), or a stretch starts (R6).
- R11: A write that lands in a boundary cycle while the holding register is empty loads the shift register directly, and no stretch occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle strobe marking the start of a transfer, treated as a byte boundary |
| scl_fall | input | 1 | One-cycle strobe at each SCL falling edge from the bit engine |
| bit_idx | input | 4 | Index of the SCL clock that is ending: 0 to 7 for data, 8 for the acknowledge clock |
| wr_en | input | 1 | Software write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | 1 when the holding register can accept a byte |
| sda_out | output | 1 | Bit value for the SDA driver, 1 meaning released |
| scl_hold | output | 1 | Request to the engine to keep SCL low |
| overrun | output | 1 | Sticky flag: a write arrived while a byte was already waiting |

## Verification
The checker assumes the engine sends no `scl_fall` while `scl_hold` is high. It also assumes `bit_idx` counts 0 to 8 in order, with one strobe per clock and none out of sequence. The bench follows both assumptions. It builds each clock from a low period, a high period and a single fall strobe. It pauses its clock task whenever it creates a stretch, and it resumes only after the write that ends the stretch. Writes, frame starts and strobes are all one cycle wide. The bench pairs a write with a fall strobe only in the boundary-collision case it is exercising.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

    localparam int unsigned TX_DATA_W = 8;

    typedef struct packed {
        logic load;
        logic shift;
        logic drop;
    } shift_ctl_t;

    typedef struct packed {
        logic boundary;
        logic wr_ok;
        logic direct;
        logic store;
        logic take;
        logic st_set;
    } tx_evt_t;

    function automatic int unsigned idx_width(input int unsigned data_w);
        return $clog2(data_w + 1);
    endfunction

endpackage

// File: rtl/i2c_tx_hold.sv
module i2c_tx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              store,
    input  logic              drain,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q,
    output logic              full,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (store) begin
                q    <= din;
                full <= 1'b1;
            end else if (drain) begin
                full <= 1'b0;
            end
            if (wr_req && full) begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_tx_stretch.sv
module i2c_tx_stretch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic hold_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (clr_req) begin
            hold_q <= 1'b0;
        end else if (set_req) begin
            hold_q <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tx_shift.sv
module i2c_tx_shift
    import i2c_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_ctl_t        ctl,
    input  logic [DATA_W-1:0] din,
    output logic              sda
);
    logic [DATA_W-1:0] sreg;
    logic              live;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            live <= 1'b0;
        end else if (ctl.load) begin
            sreg <= din;
            live <= 1'b1;
        end else if (ctl.drop) begin
            live <= 1'b0;
        end else if (ctl.shift) begin
            sreg <= {sreg[DATA_W-2:0], 1'b0};
        end
    end

    assign sda = live ? sreg[DATA_W-1] : 1'b1;
endmodule

// File: rtl/i2c_tx_stage.sv
module i2c_tx_stage
    import i2c_tx_pkg::*;
#(
    parameter int unsigned DATA_W = TX_DATA_W,
    localparam int unsigned BW    = idx_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              scl_fall,
    input  logic [BW-1:0]     bit_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              sda_out,
    output logic              scl_hold,
    output logic              overrun
);
    localparam logic [BW-1:0] ACK_V  = BW'(DATA_W);
    localparam logic [BW-1:0] LAST_V = BW'(DATA_W - 1);

    logic              full;
    logic [DATA_W-1:0] hold_q;
    logic              stretching;
    tx_evt_t           ev;
    shift_ctl_t        sctl;
    logic [DATA_W-1:0] load_data;
    logic              data_fall;

    always_comb begin
        ev.boundary = frame_start | (scl_fall & (bit_idx == ACK_V));
        ev.wr_ok    = wr_en & ~full;
        ev.direct   = ev.wr_ok & (stretching | ev.boundary);
        ev.store    = ev.wr_ok & ~ev.direct;
        ev.take     = ev.boundary & full;
        ev.st_set   = ev.boundary & ~full & ~ev.wr_ok;
    end

    assign data_fall  = scl_fall & ~ev.boundary;
    assign sctl.load  = ev.take | ev.direct;
    assign sctl.shift = data_fall & (bit_idx < LAST_V);
    assign sctl.drop  = ev.st_set | (data_fall & (bit_idx == LAST_V));
    assign load_data  = ev.direct ? wr_data : hold_q;

    i2c_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_en),
        .store   (ev.store),
        .drain   (ev.take),
        .din     (wr_data),
        .q       (hold_q),
        .full    (full),
        .overrun (overrun)
    );

    i2c_tx_stretch u_stretch (
        .clk     (clk),
        .rst     (rst),
        .set_req (ev.st_set),
        .clr_req (ev.direct),
        .hold_q  (stretching)
    );

    i2c_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk (clk),
        .rst (rst),
        .ctl (sctl),
        .din (load_data),
        .sda (sda_out)
    );

    assign tx_empty = ~full;
    assign scl_hold = stretching;
endmodule

// File: rtl/i2c_tx_stage_chk.sv
module i2c_tx_stage_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BW     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              scl_fall,
    input logic [BW-1:0]     bit_idx,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              tx_empty,
    input logic              sda_out,
    input logic              scl_hold,
    input logic              overrun
);
    logic edge_ack;
    assign edge_ack = frame_start || (scl_fall && bit_idx == BW'(DATA_W));

    AST_EMPTY_CLEARS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        tx_empty && wr_en && !scl_hold && !edge_ack |=> !tx_empty); // R2
    AST_LOAD_WITHOUT_STRETCH: assert property (@(posedge clk) disable iff (rst)
        edge_ack && !tx_empty |=> tx_empty && !scl_hold); // R3
    AST_LOAD_SHOWS_MSB: assert property (@(posedge clk) disable iff (rst)
        edge_ack && tx_empty && wr_en |=> sda_out == $past(wr_data[DATA_W-1])); // R11
    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        scl_fall && bit_idx == BW'(DATA_W - 1) |=> sda_out); // R5
    AST_STRETCH_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> $past(edge_ack)); // R6
    AST_STRETCH_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        scl_hold && !wr_en |=> scl_hold); // R6
    AST_STRETCH_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        scl_hold && wr_en |=> !scl_hold && tx_empty); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R8
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(wr_en && !tx_empty)); // R8
    AST_SDA_MOVES_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_out) |-> $past(scl_fall || frame_start || wr_en)); // R9
endmodule

bind i2c_tx_stage i2c_tx_stage_chk #(.DATA_W(DATA_W), .BW(BW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .scl_fall    (scl_fall),
    .bit_idx     (bit_idx),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .tx_empty    (tx_empty),
    .sda_out     (sda_out),
    .scl_hold    (scl_hold),
    .overrun     (overrun)
);

// File: tb/i2c_tx_stage_test.sv
module i2c_tx_stage_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       scl_fall = 1'b0;
    logic [3:0] bit_idx = 4'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_empty, sda_out, scl_hold, overrun;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tx_stage uut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .scl_fall(scl_fall),
        .bit_idx(bit_idx), .wr_en(wr_en), .wr_data(wr_data),
        .tx_empty(tx_empty), .sda_out(sda_out), .scl_hold(scl_hold), .overrun(overrun)
    );

    // behavioural reference model
    logic [7:0] pend[$];
    logic [7:0] m_cur = 8'h00;
    int         m_pos = -1;
    bit         m_str = 1'b0;
    bit         m_ovr = 1'b0;
    bit         prev_move = 1'b0;
    logic       prev_sda = 1'b1;

    always @(posedge clk) begin
        bit full_now, bnd, direct;
        prev_move = scl_fall || frame_start || wr_en;
        if (rst) begin
            pend.delete();
            m_pos = -1; m_str = 1'b0; m_ovr = 1'b0;
        end else begin
            full_now = (pend.size() != 0);
            bnd      = frame_start || (scl_fall && bit_idx == 4'd8);
            direct   = 1'b0;
            if (wr_en) begin
                if (full_now) m_ovr = 1'b1;
                else if (m_str || bnd) begin
                    m_cur = wr_data; m_pos = 0; m_str = 1'b0; direct = 1'b1;
                end else pend.push_back(wr_data);
            end
            if (bnd && !direct) begin
                if (full_now) begin m_cur = pend.pop_front(); m_pos = 0; end
                else begin m_str = 1'b1; m_pos = -1; end
            end else if (scl_fall && !bnd) begin
                if (m_pos >= 0 && m_pos < 7) m_pos++;
                else if (m_pos == 7) m_pos = -1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic m_sda;
        if (!rst && !done) begin
            m_sda = (m_pos < 0) ? 1'b1 : m_cur[7 - m_pos];
            chk(sda_out === m_sda, "R4 sda", sda_out, m_sda);
            chk(tx_empty === (pend.size() == 0), "R2 empty", tx_empty, pend.size() == 0);
            chk(scl_hold === m_str, "R6 hold", scl_hold, m_str);
            chk(overrun === m_ovr, "R8 overrun", overrun, m_ovr);
            if (sda_out !== prev_sda)
                chk(prev_move, "R9 sda change while SCL high", sda_out, prev_sda);
        end
        prev_sda = sda_out;
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bit_clock(input logic [3:0] idx, output logic seen);
        repeat (3) @(negedge clk);
        seen = sda_out;
        scl_fall = 1'b1; bit_idx = idx;
        @(negedge clk); scl_fall = 1'b0;
    endtask

    task automatic data_bits(input logic [7:0] exp);
        logic [7:0] got;
        logic b;
        for (int k = 0; k < 8; k++) begin
            bit_clock(4'(k), b);
            got[7 - k] = b;
        end
        chk(got == exp, "R4 serial byte MSB first", got, exp);
        repeat (3) @(negedge clk);
        chk(sda_out == 1'b1, "R5 released during ack", sda_out, 1);
    endtask

    task automatic ack_fall();
        scl_fall = 1'b1; bit_idx = 4'd8;
        @(negedge clk); scl_fall = 1'b0;
    endtask

    task automatic stretch_then_write(input int w, input logic [7:0] d);
        int cnt = 0;
        for (int i = 1; i <= w; i++) begin
            if (scl_hold) cnt++;
            if (i < w) @(negedge clk);
        end
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        chk(cnt == w, "R6 stretch length", cnt, w);
        chk(scl_hold == 1'b0, "R7 release after write", scl_hold, 0);
        chk(tx_empty == 1'b1, "R7 empty stays set", tx_empty, 1);
        chk(sda_out == d[7], "R7 new MSB on sda", sda_out, d[7]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_empty == 1 && scl_hold == 0 && sda_out == 1 && overrun == 0,
            "R1 reset state", {tx_empty, scl_hold, sda_out, overrun}, 4'b1010);
        rst = 1'b0;

        wr(8'hA5);
        chk(tx_empty == 1'b0, "R2 byte held", tx_empty, 0);
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        chk(tx_empty == 1 && scl_hold == 0 && sda_out == 1, "R10 frame start loads",
            {tx_empty, scl_hold, sda_out}, 3'b101);

        wr(8'h3C);
        data_bits(8'hA5);
        ack_fall();
        chk(scl_hold == 0 && tx_empty == 1, "R3 early byte no stretch", {scl_hold, tx_empty}, 2'b01);
        chk(sda_out == 1'b0, "R3 first bit of 3C", sda_out, 0);

        data_bits(8'h3C);
        ack_fall();
        stretch_then_write(6, 8'hC3);

        wr(8'h11);
        wr(8'h22);
        chk(overrun == 1'b1, "R8 overrun raised", overrun, 1);
        data_bits(8'hC3);
        ack_fall();
        data_bits(8'h11);
        chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);

        scl_fall = 1'b1; bit_idx = 4'd8; wr_en = 1'b1; wr_data = 8'h6E;
        @(negedge clk); scl_fall = 1'b0; wr_en = 1'b0;
        chk(scl_hold == 0 && tx_empty == 1, "R11 collision no stretch", {scl_hold, tx_empty}, 2'b01);
        data_bits(8'h6E);
        ack_fall();
        stretch_then_write(1, 8'h81);
        data_bits(8'h81);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        done = 1'b1;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule